// File: doc/BRIEF.md
# Vector Reciprocal Square Root Estimator

This unit takes a vector of several IEEE-754 single-precision values (four by default, 128 bits) and returns, for every lane, an approximation of one over the square root of that lane. Each finite positive operand is split into an exponent and a normalised significand. A small seed table, read at two neighbouring points and linearly interpolated, supplies the significand of the estimate. The result exponent comes from halving the negated input exponent, with a correction for the parity of that exponent. The estimate is kept to a fixed number of fraction bits, enough for about 12 correct bits.

A per-operation refine flag adds one Newton-Raphson step, x1 = x0 * (1.5 - 0.5 * b * x0 * x0), on the stored significands, which brings the result close to full single precision. A per-operation flush flag makes subnormal operands count as signed zeros. Zeros, infinities, negative values and NaNs get fixed results inside the unit. The unit keeps no status, sets no flags and raises no exception.

Operands enter through a valid/ready handshake and results leave through one. The two pipeline stages advance together whenever the output register is empty or is being taken. A result appears two cycles after its operand is accepted when nothing downstream stalls.

Top module: `rsqrt_vec_unit`

## Requirements
- R1: Lanes are packed big-endian: lane 0 uses bits 127:96 of `in_vec` and `out_vec`, lane 1 uses bits 95:64, and so on. Each lane's result depends only on that lane's operand.
- R2: With refine low, a positive finite nonzero operand gives a positive normal result whose relative error against the exact 1/sqrt is below 2^-12.
- R3: With refine high, the relative error of such a result is below 2^-20.
- R4: Any operand with sign bit 1 that is neither a zero nor a NaN gives the quiet NaN 0x7FC00000. This includes negative infinity and, when not flushed, negative subnormals.
- R5: +0 gives +infinity (0x7F800000) and -0 gives -infinity (0xFF800000).
- R6: +infinity (0x7F800000) gives +0 (0x00000000).
- R7: A NaN operand (exponent field all ones, fraction nonzero) returns its own sign and payload with fraction bit 22, the quiet bit, forced to 1.
- R8: With flush high, a subnormal operand (exponent field 0, fraction nonzero) acts as a zero of the same sign and gives ±infinity. With flush low it is evaluated as a number under R2/R3. No output is ever subnormal.
- R9: An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_vec` hold. With no stall, the result is offered two cycles after acceptance.
- R10: Every accepted operand yields exactly one result, in acceptance order, under any pattern of backpressure.
- R11: While reset is high, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand vector is present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_vec | input | 32*LANES | Packed single-precision operands, lane 0 in the top bits |
| in_flush | input | 1 | Treat subnormal operands as zero |
| in_refine | input | 1 | Apply one Newton-Raphson step |
| out_valid | output | 1 | Result vector is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 32*LANES | Packed single-precision results, lane 0 in the top bits |

## Verification
The bound checker watches properties of the output stream on every cycle. An offered result never holds a signalling NaN or a subnormal. A set sign bit only appears on an infinity or a NaN. A stalled result stays put, and reset clears the output valid. Accuracy bounds, the special-value mapping per lane, flush behaviour, lane order, latency and ordering under backpressure depend on the operand that produced each result. Only the bench's scenarios can show these, by comparing against a real-valued reference and a queue of accepted operands.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // fraction bits of the fixed-point significand path (value 1.0 == 1 << FIX_F)
  localparam int FIX_F = 24;

  typedef struct packed {
    logic              special;  // lane result is fixed, no arithmetic needed
    logic [31:0]       spec;     // that fixed result
    logic [8:0]        er;       // result exponent before normalisation shift
    logic              par;      // odd unbiased input exponent
    logic [22:0]       frac;     // normalised input fraction
    logic [FIX_F:0]    y;        // seed estimate, FIX_F fraction bits
  } mid_t;
endpackage

// File: rtl/rsq_seed_rom.sv
module rsq_seed_rom #(
  parameter int SEED_BITS = 6,
  parameter int F         = 24
) (
  input  logic                 par,
  input  logic [SEED_BITS-1:0] idx,
  output logic [F:0]           lo,
  output logic [F:0]           hi
);
  localparam int N = (1 << SEED_BITS) + 1;

  // 1/sqrt at point (1 + i/2^S) * (1 + par), computed as an integer square root
  function automatic logic [F:0] seed_val(int sb, int p, int i);
    longint unsigned num, den, r, t;
    den = (longint'(1 << sb) + longint'(i)) * longint'(p + 1);
    num = (64'd1 << (2 * F + sb)) / den;
    r = 0;
    for (int b = 29; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= num) r = t;
    end
    return r[F:0];
  endfunction

  logic [F:0] tab [2][N];

  for (genvar gp = 0; gp < 2; gp++) begin : g_par
    for (genvar gi = 0; gi < N; gi++) begin : g_pt
      localparam logic [F:0] V = seed_val(SEED_BITS, gp, gi);
      assign tab[gp][gi] = V;
    end
  end

  logic [SEED_BITS:0] i0, i1;
  assign i0 = {1'b0, idx};
  assign i1 = i0 + 1'b1;
  assign lo = tab[par][i0];
  assign hi = tab[par][i1];
endmodule

// File: rtl/rsq_lane_front.sv
module rsq_lane_front import rsq_pkg::*; #(
  parameter int SEED_BITS = 6,
  parameter int EST_BITS  = 14
) (
  input  logic [31:0] word,
  input  logic        flush,
  output mid_t        mid
);
  localparam int FR = 23 - SEED_BITS;
  localparam logic [FIX_F:0] KEEP =
    ~((FIX_F+1)'((64'd1 << (FIX_F - EST_BITS)) - 64'd1));

  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] mn;
  logic        is_nan, is_inf, is_den, is_zero;
  logic [4:0]  msb;
  logic [23:0] nrm;
  logic [9:0]  diff;
  logic [22:0] frac;
  logic        par;

  assign sgn = word[31];
  assign ex  = word[30:23];
  assign mn  = word[22:0];

  // classification and exponent path
  always_comb begin
    is_nan  = (ex == 8'hFF) && (mn != '0);
    is_inf  = (ex == 8'hFF) && (mn == '0);
    is_den  = (ex == 8'h00) && (mn != '0);
    is_zero = (ex == 8'h00) && ((mn == '0) || flush);
    msb = '0;
    for (int k = 0; k < 23; k++)
      if (mn[k]) msb = k[4:0];
    nrm = {1'b0, mn} << (5'd23 - msb);
    if (is_den) begin
      frac = nrm[22:0];
      diff = 10'd404 - {5'd0, msb};   // 382 minus effective biased exponent (msb-22)
    end else begin
      frac = mn;
      diff = 10'd382 - {2'd0, ex};
    end
    par = ~diff[0];
  end

  logic [SEED_BITS-1:0] idx;
  logic [FR-1:0]        fr;
  logic [FIX_F:0]       lo, hi, dlt, yi;
  logic [FIX_F+FR:0]    prod;

  assign idx = frac[22 -: SEED_BITS];
  assign fr  = frac[FR-1:0];

  rsq_seed_rom #(.SEED_BITS(SEED_BITS), .F(FIX_F)) u_rom (
    .par (par),
    .idx (idx),
    .lo  (lo),
    .hi  (hi)
  );

  // interpolation between neighbouring seed points, then pack the lane record
  always_comb begin
    dlt  = lo - hi;
    prod = {{FR{1'b0}}, dlt} * {{(FIX_F+1){1'b0}}, fr};
    yi   = lo - prod[FIX_F+FR:FR];
    mid.y    = yi & KEEP;
    mid.er   = diff[9:1];
    mid.par  = par;
    mid.frac = frac;
    mid.special = is_nan || is_zero || sgn || is_inf;
    if (is_nan)       mid.spec = {sgn, 8'hFF, 1'b1, mn[21:0]};
    else if (is_zero) mid.spec = {sgn, 8'hFF, 23'd0};
    else if (sgn)     mid.spec = 32'h7FC0_0000;
    else              mid.spec = 32'h0000_0000;
  end
endmodule

// File: rtl/rsq_lane_back.sv
module rsq_lane_back import rsq_pkg::*; (
  input  mid_t        mid,
  input  logic        refine,
  output logic [31:0] word
);
  logic [24:0] mb;
  logic [49:0] ysq;
  logic [25:0] ysq_t;
  logic [50:0] hm;
  logic [27:0] h, t;
  logic [52:0] xm;
  logic [25:0] x1, v;
  logic [22:0] man;
  logic [1:0]  dn;
  logic [7:0]  ex;

  always_comb begin
    // operand significand in [1,4), 23 fraction bits
    mb    = mid.par ? {1'b1, mid.frac, 1'b0} : {2'b01, mid.frac};
    ysq   = {25'd0, mid.y} * {25'd0, mid.y};
    ysq_t = ysq[49:24];
    hm    = {26'd0, mb} * {25'd0, ysq_t};
    h     = hm[50:23];
    t     = 28'd25165824 - {1'b0, h[27:1]};   // 1.5 - h/2
    xm    = {28'd0, mid.y} * {25'd0, t};
    x1    = xm[49:24];
    v     = refine ? x1 : {1'b0, mid.y};
    if (v[24]) begin
      man = v[23:1]; dn = 2'd0;
    end else if (v[23]) begin
      man = v[22:0]; dn = 2'd1;
    end else begin
      man = {v[21:0], 1'b0}; dn = 2'd2;
    end
    ex   = mid.er[7:0] - {6'd0, dn};
    word = mid.special ? mid.spec : {1'b0, ex, man};
  end
endmodule

// File: rtl/rsqrt_vec_unit.sv
module rsqrt_vec_unit import rsq_pkg::*; #(
  parameter int LANES     = 4,
  parameter int SEED_BITS = 6,
  parameter int EST_BITS  = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [32*LANES-1:0] in_vec,
  input  logic                in_flush,
  input  logic                in_refine,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [32*LANES-1:0] out_vec
);
  localparam int VW = 32 * LANES;

  logic        adv;
  logic        s1_valid, s1_ref;
  mid_t        f_mid  [LANES];
  mid_t        s1_mid [LANES];
  logic [31:0] b_word [LANES];

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rsq_lane_front #(.SEED_BITS(SEED_BITS), .EST_BITS(EST_BITS)) u_front (
      .word  (in_vec[VW-1-32*l -: 32]),
      .flush (in_flush),
      .mid   (f_mid[l])
    );
    rsq_lane_back u_back (
      .mid    (s1_mid[l]),
      .refine (s1_ref),
      .word   (b_word[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_mid <= f_mid;
      s1_ref <= in_refine;
    end
    if (adv && s1_valid)
      for (int l = 0; l < LANES; l++)
        out_vec[VW-1-32*l -: 32] <= b_word[l];
  end
endmodule

// File: rtl/rsq_vec_chk.sv
module rsq_vec_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [32*LANES-1:0] out_vec
);
  // R11
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R11
  reset_ready_chk: assert property (@(posedge clk) rst |=> in_ready);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [31:0] w;
    assign w = out_vec[32*LANES-1-32*l -: 32];

    // R7
    quiet_nan_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && w[30:23] == 8'hFF && w[22:0] != '0) |-> w[22]);

    // R8
    no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && w[30:23] == 8'h00) |-> (w[22:0] == '0));

    // R5
    neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && w[31]) |-> (w[30:23] == 8'hFF));
  end
endmodule

bind rsqrt_vec_unit rsq_vec_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec)
);

// File: tb/rsqrt_vec_unit_tb.sv
`timescale 1ns/1ps
module rsqrt_vec_unit_tb;
  localparam int LANES = 4;
  localparam int VW    = 32 * LANES;
  localparam int N_DIR = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_vec = '0;
  logic          in_flush = 1'b0;
  logic          in_refine = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_vec;

  always #2 clk = ~clk;

  rsqrt_vec_unit #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_flush(in_flush), .in_refine(in_refine),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int n_in  = 0;
  int n_out = 0;
  bit done  = 0;

  logic [VW-1:0] q_vec [$];
  bit            q_fl  [$];
  bit            q_rf  [$];
  int            q_cyc [$];
  int            q_id  [$];

  function automatic real p2(int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real fval(logic [31:0] w);
    if (w[30:23] == 8'd0) return real'(w[22:0]) * p2(-149);
    return (1.0 + real'(w[22:0]) / 8388608.0) * p2(int'(w[30:23]) - 127);
  endfunction

  function automatic logic [31:0] rnd_f32();
    logic [31:0] r, k;
    k = $urandom % 16;
    r = $urandom;
    case (k)
      9:       r = {1'b0, 8'd0, r[22:1], 1'b1};
      10:      r = {1'b1, 8'(r[30:23] % 255), r[22:0]};
      11:      r = {r[31], 31'd0};
      12:      r = {r[31], 8'hFF, 23'd0};
      13:      r = {r[31], 8'hFF, r[22:1], 1'b1};
      14:      r = {1'b0, 8'(126 + r[30:29]), r[22:0]};
      15:      r = {1'b1, 8'd0, r[22:1], 1'b1};
      default: r = {1'b0, 8'(1 + (r[30:23] % 254)), r[22:0]};
    endcase
    return r;
  endfunction

  task automatic gen_vec(int id, output logic [VW-1:0] v, output bit fl, output bit rf);
    logic [31:0] r;
    fl = 0; rf = 0;
    case (id)
      0: v = {32'h0000_0000, 32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000};
      1: v = {32'h3F80_0000, 32'h4080_0000, 32'hBF80_0000, 32'h7FA0_0001};
      2: begin v = {32'h0000_0001, 32'h8000_0001, 32'h007F_FFFF, 32'h0040_0000}; fl = 1; end
      3: v = {32'h0000_0001, 32'h8000_0001, 32'h007F_FFFF, 32'h0040_0000};
      4: begin v = {32'h3F80_0000, 32'h4000_0000, 32'h7F7F_FFFF, 32'h0080_0000}; rf = 1; end
      5: v = {32'h3F80_0000, 32'h4000_0000, 32'h7F7F_FFFF, 32'h0080_0000};
      6: begin v = {32'h3FFF_FFFF, 32'h407F_FFFF, 32'h4000_0001, 32'hFFC1_2345}; rf = 1; end
      default: begin
        for (int l = 0; l < LANES; l++) v[VW-1-32*l -: 32] = rnd_f32();
        r = $urandom;
        fl = r[0]; rf = r[1];
      end
    endcase
  endtask

  task automatic fail(string tag, string what, string act, string exp);
    bad++;
    $display("FAIL %s %s actual=%s expected=%s", tag, what, act, exp);
  endtask

  task automatic check_lane(int id, int l, logic [31:0] a, logic [31:0] got, bit fl, bit rf);
    logic [31:0] ex;
    string tag;
    bit approx = 0;
    real refv, gv, rel, bound;
    total++;
    if (a[30:23] == 8'hFF && a[22:0] != '0) begin
      ex = {a[31], 8'hFF, 1'b1, a[21:0]}; tag = "R7";
    end else if (a[30:23] == 8'd0 && (a[22:0] == '0 || fl)) begin
      ex = a[31] ? 32'hFF80_0000 : 32'h7F80_0000;
      tag = (a[22:0] == '0) ? "R5" : "R8";
    end else if (a[31]) begin
      ex = 32'h7FC0_0000; tag = "R4";
    end else if (a[30:23] == 8'hFF) begin
      ex = 32'h0000_0000; tag = "R6";
    end else begin
      approx = 1;
      tag = rf ? "R3" : ((a[30:23] == 8'd0) ? "R8" : "R2");
    end
    if (!approx) begin
      if (got !== ex)
        fail(tag, $sformatf("op %0d lane %0d in=%h", id, l, a),
             $sformatf("%h", got), $sformatf("%h", ex));
    end else begin
      refv  = 1.0 / $sqrt(fval(a));
      bound = rf ? p2(-20) : p2(-12);
      if (got[31] !== 1'b0 || got[30:23] == 8'd0 || got[30:23] == 8'hFF) begin
        fail(tag, $sformatf("op %0d lane %0d in=%h not positive normal", id, l, a),
             $sformatf("%h", got), $sformatf("~%e", refv));
      end else begin
        gv  = fval(got);
        rel = (gv - refv) / refv;
        if (rel < 0.0) rel = -rel;
        if (!(rel < bound))
          fail(tag, $sformatf("op %0d lane %0d in=%h rel err %e", id, l, a, rel),
               $sformatf("%e", gv), $sformatf("%e", refv));
      end
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // streams n operands starting at id base; stall selects random valid/ready
  task automatic run_phase(int base, int n, bit stall);
    int sent = 0;
    bit hold_in = 0;
    bit hold_out = 0;
    logic [VW-1:0] held;
    logic [VW-1:0] v, qv;
    bit fl, rf, qf, qr;
    int qc, qi;
    int idle = 0;
    while (n_out < base + n && idle < 2000) begin
      @(negedge clk);
      cyc++;
      idle++;
      if (!hold_in) begin
        if (sent < n && (!stall || ($urandom % 4) != 0)) begin
          gen_vec(base + sent, v, fl, rf);
          in_vec = v; in_flush = fl; in_refine = rf; in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (hold_out) begin
        total++;
        if (!out_valid || out_vec !== held)
          fail("R9", "stalled result changed", $sformatf("%b/%h", out_valid, out_vec),
               $sformatf("1/%h", held));
      end
      hold_out = out_valid && !out_ready;
      held = out_vec;
      if (out_valid && out_ready) begin
        idle = 0;
        total++;
        if (q_vec.size() == 0) begin
          fail("R10", "result with no accepted operand", "extra", "none");
        end else begin
          qv = q_vec.pop_front(); qf = q_fl.pop_front(); qr = q_rf.pop_front();
          qc = q_cyc.pop_front(); qi = q_id.pop_front();
          if (!stall && (cyc - qc) != 2)
            fail("R9", $sformatf("latency op %0d", qi), $sformatf("%0d", cyc - qc), "2");
          for (int l = 0; l < LANES; l++)
            check_lane(qi, l, qv[VW-1-32*l -: 32], out_vec[VW-1-32*l -: 32], qf, qr);
          if (qi == 0) begin
            total++;
            if (out_vec !== {32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h7FC0_0000})
              fail("R1", "lane order", $sformatf("%h", out_vec),
                   "7f800000ff800000000000007fc00000");
          end
        end
        n_out++;
      end
      if (in_valid && in_ready) begin
        q_vec.push_back(in_vec); q_fl.push_back(in_flush); q_rf.push_back(in_refine);
        q_cyc.push_back(cyc); q_id.push_back(base + sent);
        sent++; n_in++;
        hold_in = 0;
      end else begin
        hold_in = in_valid;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++;
      fail("R9", "watchdog expired", "hung", "done");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1)
      fail("R11", "reset state out_valid/in_ready", $sformatf("%b/%b", out_valid, in_ready), "0/1");
    rst = 1'b0;
    run_phase(0, N_DIR + 120, 1'b0);
    run_phase(N_DIR + 120, 400, 1'b1);
    repeat (4) @(negedge clk);
    total++;
    if (n_in != n_out || q_vec.size() != 0 || out_valid !== 1'b0)
      fail("R10", "accepted vs delivered", $sformatf("%0d/%0d", n_in, n_out),
           $sformatf("%0d/%0d", n_in, n_in));
    done = 1;
    finish_up();
  end
endmodule